// File: doc/BRIEF.md
# Rule Antecedent Coverage Monitor

This block sits beside a protocol rule checker and records how much of the protocol a simulation run has exercised. Every rule has the form "if some past condition held, the current signals must satisfy X". The condition part is the rule's antecedent. Until an antecedent has been true at least once, nothing is known about whether the design obeys that rule. The monitor gets one antecedent term per rule every cycle. The checker computes these terms from its own registered history, so a term may stand for a plain signal condition or for a counter state, such as a wait counter that has reached its limit while a ready signal is still low.

For each rule the monitor keeps a sticky hit bit and a saturating count of the cycles in which that antecedent fired. It also reports how many distinct rules have been hit. Coverage is this distinct count divided by the rule total. Rules are split into two groups. The lowest `ENV_RULES` indices are rules that constrain the environment, and the rest are rules the design must obey. Each group gets its own distinct-hit count. A synchronous clear input starts a new measurement window without a reset. The block only observes and reports. It does not interpret the figures or steer stimulus.

Top module: `cov_antecedent_mon`

## Requirements
- R1: While `rst_n` is low, `hit`, every fire counter, `hit_total`, `hit_env` and `hit_dut` are zero.
- R2: If `ante[i]` is 1 at a rising edge and `clr` is 0, then `hit[i]` is 1 after that edge. It stays 1 until a clear or a reset.
- R3: Each rising edge with `ante[i]` at 1 and `clr` at 0 adds one to rule i's fire counter. That counter is `fire_cnt[i*CW +: CW]`.
- R4: A fire counter that holds all ones stays at all ones while its antecedent keeps firing. It does not wrap.
- R5: A rising edge with `clr` at 1 sets every hit bit and every fire counter to zero. Any `ante` bits at that edge are ignored.
- R6: After each rising edge, `hit_total` equals the number of bits that were set in `hit` just before that edge. It therefore follows a newly set hit bit one cycle later.
- R7: With the same one-cycle lag, `hit_env` counts the set hit bits with index below `ENV_RULES` and `hit_dut` counts the set hit bits at or above it. Their sum equals `hit_total`.
- R8: A rising edge with `ante[i]` at 0 and `clr` at 0 leaves rule i's fire counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of hits and counters |
| ante | input | NRULE | Antecedent truth per rule for this cycle |
| hit | output | NRULE | Sticky per-rule hit bitmap |
| fire_cnt | output | NRULE*CW | Packed per-rule saturating fire counters |
| hit_total | output | $clog2(NRULE+1) | Distinct rules hit |
| hit_env | output | $clog2(NRULE+1) | Distinct environment-side rules hit |
| hit_dut | output | $clog2(NRULE+1) | Distinct design-side rules hit |

## Verification
The bench builds the monitor with six rules, a 5-bit counter width and two environment-side rules. With only 31 counts to the ceiling, a single rule that is held active reaches saturation in a few dozen cycles. The small rule count means random sparse antecedents fill the bitmap, clears empty it again, and both group counts pass through every value. The same design with its 16-bit default would need tens of thousands of cycles before one counter could saturate.

// File: rtl/cov_antecedent_mon.sv
module cov_antecedent_mon #(
  parameter int NRULE     = 8,
  parameter int CW        = 16,
  parameter int ENV_RULES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic [NRULE-1:0]           ante,
  output logic [NRULE-1:0]           hit,
  output logic [NRULE*CW-1:0]        fire_cnt,
  output logic [$clog2(NRULE+1)-1:0] hit_total,
  output logic [$clog2(NRULE+1)-1:0] hit_env,
  output logic [$clog2(NRULE+1)-1:0] hit_dut
);
  localparam int NW = $clog2(NRULE+1);

  logic [NRULE-1:0] env_mask;

  function automatic logic [NW-1:0] popcnt(input logic [NRULE-1:0] v);
    logic [NW-1:0] n;
    n = '0;
    for (int k = 0; k < NRULE; k++) n = n + NW'(v[k]);
    return n;
  endfunction

  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    logic [CW-1:0] cnt;
    assign env_mask[g] = (g < ENV_RULES);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (ante[g] && ~&cnt)     cnt <= cnt + 1'b1;
    end
    assign fire_cnt[g*CW +: CW] = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hit <= '0;
    else if (clr) hit <= '0;
    else          hit <= hit | ante;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_total <= '0;
      hit_env   <= '0;
      hit_dut   <= '0;
    end else begin
      hit_total <= popcnt(hit);
      hit_env   <= popcnt(hit & env_mask);
      hit_dut   <= popcnt(hit & ~env_mask);
    end
  end
endmodule

// File: rtl/cov_antecedent_mon_chk.sv
module cov_antecedent_mon_chk #(
  parameter int NRULE     = 8,
  parameter int CW        = 16,
  parameter int ENV_RULES = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr,
  input logic [NRULE-1:0]           ante,
  input logic [NRULE-1:0]           hit,
  input logic [NRULE*CW-1:0]        fire_cnt,
  input logic [$clog2(NRULE+1)-1:0] hit_total,
  input logic [$clog2(NRULE+1)-1:0] hit_env,
  input logic [$clog2(NRULE+1)-1:0] hit_dut
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |-> (hit == '0 && hit_total == '0)); // R1
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) armed && !$past(clr) |-> ((hit & $past(hit)) == $past(hit))); // R2
  AST_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n) armed && !$past(clr) |-> ((hit & $past(ante)) == $past(ante))); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) armed && $past(clr) |-> (hit == '0 && fire_cnt == '0)); // R5
  AST_TOTAL_LAG: assert property (@(posedge clk) disable iff (!rst_n) armed |-> (32'(hit_total) == $countones($past(hit)))); // R6
  AST_GROUP_SUM: assert property (@(posedge clk) disable iff (!rst_n) (32'(hit_env) + 32'(hit_dut)) == 32'(hit_total)); // R7

  for (genvar g = 0; g < NRULE; g++) begin : g_chk
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(clr) && $past(ante[g]) && !(&$past(fire_cnt[g*CW +: CW])) |->
      (fire_cnt[g*CW +: CW] == $past(fire_cnt[g*CW +: CW]) + 1'b1)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(clr) && (&$past(fire_cnt[g*CW +: CW])) |-> (&fire_cnt[g*CW +: CW])); // R4
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(clr) && !$past(ante[g]) |-> $stable(fire_cnt[g*CW +: CW])); // R8
  end
endmodule

bind cov_antecedent_mon cov_antecedent_mon_chk #(.NRULE(NRULE), .CW(CW), .ENV_RULES(ENV_RULES)) u_chk (.*);

// File: tb/test_cov_antecedent_mon.sv
`timescale 1ns/1ps
module test_cov_antecedent_mon;
  localparam int NR = 6;
  localparam int CW = 5;
  localparam int NE = 2;
  localparam int NW = $clog2(NR+1);
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [NR-1:0] ante = '0;
  logic [NR-1:0] hit;
  logic [NR*CW-1:0] fire_cnt;
  logic [NW-1:0] hit_total, hit_env, hit_dut;

  int total = 0, bad = 0;
  logic [NR-1:0] m_hit = '0;
  int m_cnt [NR];
  int m_tot = 0, m_env = 0, m_dut = 0;

  always #4 clk = ~clk;

  cov_antecedent_mon #(.NRULE(NR), .CW(CW), .ENV_RULES(NE)) i_cov_antecedent_mon (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ante(ante), .hit(hit),
    .fire_cnt(fire_cnt), .hit_total(hit_total), .hit_env(hit_env), .hit_dut(hit_dut));

  function automatic int ones(input logic [NR-1:0] v, input int lo, input int hi);
    int n = 0;
    for (int k = lo; k < hi; k++) n += int'(v[k]);
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [NR-1:0] a, input logic c);
    for (int i = 0; i < NR; i++) begin
      int act = int'(fire_cnt[i*CW +: CW]);
      if (c)                  chk("R5 counter", act, m_cnt[i]);
      else if (!a[i])         chk("R8 counter", act, m_cnt[i]);
      else if (m_cnt[i]==SAT) chk("R4 counter", act, m_cnt[i]);
      else                    chk("R3 counter", act, m_cnt[i]);
    end
    chk(c ? "R5 hit" : "R2 hit", int'(hit), int'(m_hit));
    chk("R6 total", int'(hit_total), m_tot);
    chk("R7 env", int'(hit_env), m_env);
    chk("R7 dut", int'(hit_dut), m_dut);
  endtask

  task automatic step(input logic [NR-1:0] a, input logic c);
    ante = a;
    clr = c;
    @(posedge clk);
    m_tot = ones(m_hit, 0, NR);
    m_env = ones(m_hit, 0, NE);
    m_dut = ones(m_hit, NE, NR);
    if (c) begin
      m_hit = '0;
      for (int i = 0; i < NR; i++) m_cnt[i] = 0;
    end else begin
      m_hit = m_hit | a;
      for (int i = 0; i < NR; i++) if (a[i] && m_cnt[i] < SAT) m_cnt[i]++;
    end
    @(negedge clk);
    check_all(a, c);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    for (int i = 0; i < NR; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 hit", int'(hit), 0);
    chk("R1 counters", int'(fire_cnt), 0);
    chk("R1 total", int'(hit_total), 0);
    chk("R1 env", int'(hit_env), 0);
    chk("R1 dut", int'(hit_dut), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step(6'b000100, 1'b0);
    chk("R6 lag: total still old", int'(hit_total), 0);
    step(6'b000000, 1'b0);
    chk("R6 lag: total follows", int'(hit_total), 1);
    step(6'b000001, 1'b0);
    step(6'b000000, 1'b0);
    chk("R7 env after rule 0", int'(hit_env), 1);
    chk("R7 dut after rule 2", int'(hit_dut), 1);

    for (int k = 0; k < 40; k++) step(6'b001000, 1'b0);
    chk("R4 saturated", int'(fire_cnt[3*CW +: CW]), SAT);

    step(6'b111111, 1'b1);
    chk("R5 hit cleared", int'(hit), 0);
    step(6'b000000, 1'b0);
    step(6'b000000, 1'b0);
    chk("R6 total after clear", int'(hit_total), 0);

    for (int k = 0; k < 600; k++) begin
      logic [NR-1:0] a;
      for (int b = 0; b < NR; b++) a[b] = (($urandom % 8) == 0);
      step(a, ($urandom % 50) == 0);
    end

    for (int k = 0; k < 40; k++) step(6'b111111, 1'b0);
    step(6'b000000, 1'b0);
    chk("R7 all env hit", int'(hit_env), NE);
    chk("R7 all dut hit", int'(hit_dut), NR - NE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule